// File: doc/BRIEF.md
# Configuration Header Register File (Standard Header, One Memory Window)

This block is the configuration register file of a single-function device on a shared local bus. A host-side agent sends configuration requests over a simple synchronous request/response port. Each request carries a device-select strobe, a read/write flag, a 6-bit dword index (address bits 7 to 2 of a 256-byte space) and four byte enables. The block only acts on a request while its device-select input is high. It answers one clock later.

The block holds the identity fields (vendor, device, revision, subclass, class) as read-only parameters. It also holds a small command register, a read-only status word, and a header-type byte that carries a multi-function flag. One 32-bit memory base-address window has a size fixed by a parameter. Its low address bits are hard-wired to zero. Writing all ones and reading the value back therefore reveals the window size and its required alignment. Every other dword of the space reads as zero and ignores writes.

Top module: `cfg_hdr_target`

## Requirements
- R1: A request with `req_valid` and `req_sel` high produces `rsp_valid` high for exactly one cycle on the next clock edge. A request with `req_sel` low produces no response and changes no register.
- R2: Dword index 0 reads `{DEVICE_ID, VENDOR_ID}`, with the vendor ID in bits 15:0. Writes to it have no effect.
- R3: Dword index 1 reads the command register in bits 15:0 and the read-only `STATUS_VAL` in bits 31:16. Only command bits 2:0 are writable, all reset to 0, and command bits 15:3 always read 0.
- R4: Dword index 2 reads `{CLASS_CODE, SUBCLASS, 8'h00, REVISION}`, with the revision in bits 7:0. It is read-only.
- R5: Dword index 3 reads the header-type byte in bits 23:16 as `{MULTI_FUNC, 7'h00}`, and zero in every other bit. It is read-only.
- R6: Dword index 4 is the base-address window. It resets to 0. Bits below `BAR_SIZE_LOG2` (including bit 0, which reads 0 to mark memory space) always read 0. After an all-ones write it reads `32'hFFFF_FFFF << BAR_SIZE_LOG2`.
- R7: Byte lanes are little-endian. Byte enable bit k guards data bits 8k+7:8k, and a write changes only bits that are both enabled and writable.
- R8: Reads of dword indices 5 to 63 return 0, and writes to them change nothing.
- R9: A write response returns `rsp_rdata` of 0. A read has no side effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_sel | input | 1 | Device select for this function |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 6 | Dword index (address bits 7:2) |
| req_be | input | 4 | Byte enables, bit k for byte lane k |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after an accepted request |
| rsp_rdata | output | 32 | Read data (0 on writes) |

## Verification
The bench goes after three kinds of fault:
- **Window mask.** It sweeps all sixteen byte-enable patterns of an all-ones write to the window. A mask off by one bit, or a byte-lane swap, would show up as a wrong read-back size or a byte landing in the wrong lane.
- **Command register.** It writes ones to the command word with every lane combination. A design that made the upper command bits or the status half writable would read back nonzero or altered bits there.
- **Select and unused space.** It reads and writes all 64 indices, and also issues writes with device select low. A decoder that aliased indices, leaked writes into unused dwords, or acted on unselected requests would return nonzero data or a changed window.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

    localparam int unsigned IDX_W = 6;
    localparam int unsigned DW    = 32;

    localparam logic [IDX_W-1:0] IDX_IDENT  = 6'd0;
    localparam logic [IDX_W-1:0] IDX_CMDSTS = 6'd1;
    localparam logic [IDX_W-1:0] IDX_CLASS  = 6'd2;
    localparam logic [IDX_W-1:0] IDX_HDR    = 6'd3;
    localparam logic [IDX_W-1:0] IDX_WIN    = 6'd4;

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] rdata;
    } cfg_rsp_t;

endpackage

// File: rtl/cfg_field_reg.sv
module cfg_field_reg #(
    parameter int unsigned W      = 16,
    parameter logic [W-1:0] WMASK  = '1,
    parameter logic [W-1:0] RSTVAL = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [W/8-1:0] be,
    input  logic [W-1:0]   wdata,
    output logic [W-1:0]   q
);
    localparam int unsigned NB = W / 8;

    logic [W-1:0] lane_mask;
    logic [W-1:0] upd_mask;
    logic [W-1:0] q_d, q_q;

    generate
        for (genvar b = 0; b < NB; b++) begin : g_lane
            assign lane_mask[8*b +: 8] = {8{be[b]}};
        end
    endgenerate

    assign upd_mask = lane_mask & WMASK;

    always_comb begin
        q_d = q_q;
        if (wr_en) begin
            q_d = (q_q & ~upd_mask) | (wdata & upd_mask);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= RSTVAL;
        else        q_q <= q_d;
    end

    assign q = q_q;

    // Without an enabled lane the stored value must not move
    assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || (be == '0)) |=> $stable(q_q));

    // Bits outside the writable mask never leave their reset value
    assert_ro_bits_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((q_q & ~WMASK) == (RSTVAL & ~WMASK)));

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'h1D0F,
    parameter logic [15:0] DEVICE_ID  = 16'hA5C3,
    parameter logic [7:0]  REVISION   = 8'h02,
    parameter logic [7:0]  SUBCLASS   = 8'h80,
    parameter logic [7:0]  CLASS_CODE = 8'h05,
    parameter logic [15:0] STATUS_VAL = 16'h0200,
    parameter logic        MULTI_FUNC = 1'b0
) (
    input  logic [IDX_W-1:0] index,
    input  logic [15:0]      cmd,
    input  logic [DW-1:0]    win,
    output logic [DW-1:0]    rdata
);
    always_comb begin
        rdata = '0;
        unique case (index)
            IDX_IDENT:  rdata = {DEVICE_ID, VENDOR_ID};
            IDX_CMDSTS: rdata = {STATUS_VAL, cmd};
            IDX_CLASS:  rdata = {CLASS_CODE, SUBCLASS, 8'h00, REVISION};
            IDX_HDR:    rdata = {8'h00, MULTI_FUNC, 7'h00, 16'h0000};
            IDX_WIN:    rdata = win;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/cfg_hdr_target.sv
module cfg_hdr_target
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID     = 16'h1D0F,
    parameter logic [15:0] DEVICE_ID     = 16'hA5C3,
    parameter logic [7:0]  REVISION      = 8'h02,
    parameter logic [7:0]  SUBCLASS      = 8'h80,
    parameter logic [7:0]  CLASS_CODE    = 8'h05,
    parameter logic [15:0] STATUS_VAL    = 16'h0200,
    parameter logic        MULTI_FUNC    = 1'b0,
    parameter int unsigned BAR_SIZE_LOG2 = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_sel,
    input  logic        req_write,
    input  logic [5:0]  req_index,
    input  logic [3:0]  req_be,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata
);
    localparam logic [15:0]   CMD_WMASK = 16'h0007;
    localparam logic [DW-1:0] WIN_WMASK = {DW{1'b1}} << BAR_SIZE_LOG2;

    logic          accept;
    logic          wr_cmd, wr_win;
    logic [15:0]   cmd_q;
    logic [DW-1:0] win_q;
    logic [DW-1:0] mux_data;
    cfg_rsp_t      rsp_d, rsp_q;

    assign accept = req_valid && req_sel;
    assign wr_cmd = accept && req_write && (req_index == IDX_CMDSTS);
    assign wr_win = accept && req_write && (req_index == IDX_WIN);

    cfg_field_reg #(.W(16), .WMASK(CMD_WMASK), .RSTVAL(16'h0000)) u_cmd (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_cmd),
        .be    (req_be[1:0]),
        .wdata (req_wdata[15:0]),
        .q     (cmd_q)
    );

    cfg_field_reg #(.W(DW), .WMASK(WIN_WMASK), .RSTVAL('0)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_win),
        .be    (req_be),
        .wdata (req_wdata),
        .q     (win_q)
    );

    cfg_read_mux #(
        .VENDOR_ID  (VENDOR_ID),
        .DEVICE_ID  (DEVICE_ID),
        .REVISION   (REVISION),
        .SUBCLASS   (SUBCLASS),
        .CLASS_CODE (CLASS_CODE),
        .STATUS_VAL (STATUS_VAL),
        .MULTI_FUNC (MULTI_FUNC)
    ) u_mux (
        .index (req_index),
        .cmd   (cmd_q),
        .win   (win_q),
        .rdata (mux_data)
    );

    always_comb begin
        rsp_d = '0;
        if (accept) begin
            rsp_d.valid = 1'b1;
            rsp_d.rdata = req_write ? '0 : mux_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_rdata = rsp_q.rdata;

    assert_rsp_needs_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_sel));

    assert_unsel_no_change_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_sel) |=> ($stable(win_q) && $stable(cmd_q) && !rsp_valid));

    assert_cmd_high_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && $past(req_index == IDX_CMDSTS && !req_write)
        |-> (rsp_rdata[15:3] == '0 && rsp_rdata[31:16] == STATUS_VAL));

    assert_win_low_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && $past(req_index == IDX_WIN && !req_write)
        |-> ((rsp_rdata & ~WIN_WMASK) == '0));

    assert_unused_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && $past(req_index > IDX_WIN && !req_write) |-> (rsp_rdata == '0));

    assert_write_rsp_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && $past(req_write) |-> (rsp_rdata == '0));

endmodule

// File: tb/tb_cfg_hdr_target.sv
`timescale 1ns/1ps
module tb_cfg_hdr_target;
    localparam logic [15:0] VEN  = 16'h1D0F;
    localparam logic [15:0] DEV  = 16'hA5C3;
    localparam logic [7:0]  REV  = 8'h02;
    localparam logic [7:0]  SUB  = 8'h80;
    localparam logic [7:0]  CLS  = 8'h05;
    localparam logic [15:0] STS  = 16'h0200;
    localparam logic        MF   = 1'b1;
    localparam int unsigned LOG2 = 12;
    localparam logic [31:0] WMSK = 32'hFFFF_FFFF << LOG2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_sel = 1'b0, req_write = 1'b0;
    logic [5:0]  req_index = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    logic [2:0]  m_cmd = '0;
    logic [31:0] m_win = '0;

    always #2.5 clk = ~clk;

    cfg_hdr_target #(
        .VENDOR_ID(VEN), .DEVICE_ID(DEV), .REVISION(REV), .SUBCLASS(SUB),
        .CLASS_CODE(CLS), .STATUS_VAL(STS), .MULTI_FUNC(MF), .BAR_SIZE_LOG2(LOG2)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
        .req_write(req_write), .req_index(req_index), .req_be(req_be),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lanes(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic logic [31:0] exp_read(input logic [5:0] idx);
        case (idx)
            6'd0: return {DEV, VEN};
            6'd1: return {STS, 13'd0, m_cmd};
            6'd2: return {CLS, SUB, 8'h00, REV};
            6'd3: return {8'h00, MF, 7'h00, 16'h0000};
            6'd4: return m_win;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_write(input logic [5:0] idx, input logic [3:0] be, input logic [31:0] d);
        logic [31:0] m = lanes(be);
        if (idx == 6'd1) m_cmd = (m_cmd & ~m[2:0]) | (d[2:0] & m[2:0]);
        if (idx == 6'd4) m_win = (m_win & ~(m & WMSK)) | (d & m & WMSK);
    endtask

    // One request; sample the response at the following falling edge
    task automatic xfer(input logic sel, input logic wr, input logic [5:0] idx,
                        input logic [3:0] be, input logic [31:0] d,
                        output logic v, output logic [31:0] r);
        @(negedge clk);
        req_valid = 1'b1; req_sel = sel; req_write = wr;
        req_index = idx; req_be = be; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_sel = 1'b0; req_write = 1'b0;
        v = rsp_valid; r = rsp_rdata;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 response longer than one cycle actual=1 expected=0");
        end
    endtask

    task automatic rd(input string req, input logic [5:0] idx);
        logic v; logic [31:0] r;
        xfer(1'b1, 1'b0, idx, 4'hF, 32'h0, v, r);
        check("R1 valid", {31'd0, v}, 32'd1);
        check(req, r, exp_read(idx));
    endtask

    task automatic wr(input logic [5:0] idx, input logic [3:0] be, input logic [31:0] d);
        logic v; logic [31:0] r;
        xfer(1'b1, 1'b1, idx, be, d, v, r);
        check("R1 valid", {31'd0, v}, 32'd1);
        check("R9 write data zero", r, 32'h0);
        model_write(idx, be, d);
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);

        // Reset state of the whole space (R2 R3 R4 R5 R6 R8)
        for (int i = 0; i < 64; i++) rd("R8 reset sweep", 6'(i));

        // R6 R7: every byte-enable pattern of an all-ones write to the window
        for (int b = 0; b < 16; b++) begin
            wr(6'd4, 4'hF, 32'h0);
            wr(6'd4, 4'(b), 32'hFFFF_FFFF);
            rd("R7 window lanes", 6'd4);
        end
        wr(6'd4, 4'hF, 32'hFFFF_FFFF);
        rd("R6 window size", 6'd4);
        check("R6 size value", m_win, WMSK);

        // R3 R7: command lanes and pattern
        for (int b = 0; b < 16; b++) begin
            wr(6'd1, 4'h0 | 4'(b), 32'h0000_0000);
            wr(6'd1, 4'(b), 32'hFFFF_FFFF);
            rd("R3 command lanes", 6'd1);
        end
        wr(6'd1, 4'b0001, 32'h0000_0005);
        rd("R3 command pattern", 6'd1);

        // R1: unselected write must not touch the window nor respond
        begin
            logic v; logic [31:0] r;
            xfer(1'b0, 1'b1, 6'd4, 4'hF, 32'h1234_5678, v, r);
            check("R1 no response unselected", {31'd0, v}, 32'd0);
            rd("R1 window unchanged", 6'd4);
        end

        // R2 R4 R5 R8: write ones everywhere read-only/unused, then read all
        for (int i = 0; i < 64; i++) if (i != 1 && i != 4) wr(6'(i), 4'hF, 32'hFFFF_FFFF);
        for (int i = 0; i < 64; i++) rd("R8 post-write sweep", 6'(i));

        // R9: repeated reads do not disturb state
        rd("R9 read no side effect", 6'd4);
        rd("R9 read no side effect", 6'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule